// File: doc/BRIEF.md
# Strobed Handshake Parallel Port

This block is an 8-bit parallel port that sits on a simple register read/write bus. It has one bidirectional data port with a direction register and a capture register. It also has an auxiliary output port, one strobe input and one strobe output. A control/status register chooses how the two strobe pins behave:

- **Simple strobe.** Strobe-in edges capture the data pins, and writes to the auxiliary port emit a strobe-out pulse.
- **Input handshake.** Pulsed or interlocked.
- **Output handshake.** Pulsed or interlocked.

Every accepted strobe-in edge sets a status flag, and the flag can raise an interrupt.

The strobe input passes through a two-stage synchroniser and an edge detector. The strobe output is either a fixed 2-cycle pulse or a held level, and its polarity is programmable. The status flag is cleared by a two-step software sequence: read the status, then read the data. A stray data read therefore does not lose an event.

Register map:

| Address | Register |
|---|---|
| 0 | control/status |
| 1 | capture register |
| 2 | auxiliary output |
| 3 | direction |

Control bits:

| Bit | Name | Meaning |
|---|---|---|
| 0 | strobe-out polarity | 1 = active high |
| 1 | strobe-in edge | 1 = rising, 0 = falling |
| 2 | pulsed | 1 = pulsed handshake |
| 3 | output handshake | 1 = output handshake |
| 4 | handshake enable | 1 = handshake modes |
| 5 | spare | read/write, no function |
| 6 | interrupt enable | 1 = interrupt enabled |
| 7 | status flag | read-only |

Top module: `pport_top`

## Requirements
- R1: After reset, `dio_oe`, `dio_out`, `aux_out` and the control register are 0, `irq` is 0, and `stb_out` is high (inactive, active-low default).
- R2: An active strobe-in edge (falling when control bit 1 is 0, rising when it is 1) sets status bit 7. Outside output-handshake mode it also loads `dio_in` into the capture register. Both take effect on the third rising clock after the pin changes.
- R3: A strobe-in edge of the inactive direction changes neither the capture register nor the flag.
- R4: `irq` equals status bit 7 ANDed with control bit 6.
- R5: The flag clears only on a capture-register read (address 1) that follows a status read (address 0) made while the flag was set. A capture read without that prior status read leaves the flag set. A new edge in the same cycle as the clearing read keeps the flag set.
- R6: In simple mode (control bit 4 = 0), a write to address 2 drives `aux_out` and asserts strobe-out for exactly 2 clock cycles.
- R7: Control bit 0 selects the strobe-out level: active high when 1, active low when 0.
- R8: In pulsed input handshake (bits 4,3,2 = 1,0,1), a read of the capture register emits a 2-cycle strobe-out pulse.
- R9: In interlocked input handshake (bits 4,3,2 = 1,0,0), strobe-out is a ready level. It is asserted out of reset, negated when an edge captures data, and reasserted by a capture-register read.
- R10: In pulsed output handshake (bits 4,3,2 = 1,1,1), a write to address 1 drives `dio_out` and emits a 2-cycle strobe-out pulse. A later strobe-in edge sets the flag and leaves the register unchanged.
- R11: In interlocked output handshake (bits 4,3,2 = 1,1,0), a write to address 1 asserts strobe-out. Strobe-out stays asserted until an active strobe-in edge is accepted.
- R12: The direction register (address 3) drives `dio_oe`. Writes to address 1 outside output-handshake mode are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 2 | Register address |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| dio_in | input | 8 | Data port pin inputs |
| dio_out | output | 8 | Data port output values (capture register) |
| dio_oe | output | 8 | Per-pin output enable |
| aux_out | output | 8 | Auxiliary strobed output port |
| stb_in | input | 1 | Asynchronous strobe input |
| stb_out | output | 1 | Strobe output (pulse or level) |
| irq | output | 1 | Interrupt request |

## Verification
The bench targets the flag-clear ordering. A design that clears on any data read would drop the flag when the data is read without a prior status read.

It measures the strobe-out pulse width. A counter off by one would give 1 or 3 active cycles instead of 2.

It exercises the inactive strobe edge. A detector that ignores the edge-select bit would overwrite the capture register on the wrong transition.

It also checks that the held levels in both interlocked modes release only on their proper event. A wrong release would negate ready early, or drop the output strobe before the acknowledge edge arrives.

// File: rtl/pport_pkg.sv
package pport_pkg;
  localparam int unsigned AW = 2;

  localparam logic [AW-1:0] A_CTRL  = 2'd0;
  localparam logic [AW-1:0] A_LATCH = 2'd1;
  localparam logic [AW-1:0] A_AUX   = 2'd2;
  localparam logic [AW-1:0] A_DIR   = 2'd3;

  localparam int unsigned C_POL   = 0;
  localparam int unsigned C_RISE  = 1;
  localparam int unsigned C_PULSE = 2;
  localparam int unsigned C_OUT   = 3;
  localparam int unsigned C_HS    = 4;
  localparam int unsigned C_IEN   = 6;
  localparam int unsigned C_FLAG  = 7;

  typedef enum logic [1:0] {
    M_SIMPLE = 2'd0,
    M_HS_IN  = 2'd1,
    M_HS_OUT = 2'd2
  } mode_e;

  function automatic mode_e mode_of(input logic hs, input logic out_dir);
    if (!hs)         return M_SIMPLE;
    else if (out_dir) return M_HS_OUT;
    else              return M_HS_IN;
  endfunction

  function automatic logic drive_level(input logic act, input logic pol);
    return pol ? act : ~act;
  endfunction

  function automatic logic edge_hit(input logic now_v, input logic prev_v,
                                    input logic rise_sel);
    return rise_sel ? (now_v & ~prev_v) : (~now_v & prev_v);
  endfunction
endpackage

// File: rtl/pport_edge_sync.sv
module pport_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  input  logic rise_sel,
  output logic evt
);
  import pport_pkg::*;

  logic [STAGES-1:0] chain;
  logic              prev_q;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[g] <= 1'b0;
          else        chain[g] <= pin;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[g] <= 1'b0;
          else        chain[g] <= chain[g-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= chain[STAGES-1];

  assign evt = edge_hit(chain[STAGES-1], prev_q, rise_sel);

  // R2: one accepted edge per transition unless the edge selection changed
  assert_single_edge_R2: assert property (@(posedge clk) disable iff (!rst_n)
    evt |=> (!evt || (rise_sel != $past(rise_sel))));
endmodule

// File: rtl/pport_strobe_gen.sv
module pport_strobe_gen #(
  parameter int unsigned PULSE_CYCLES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trig,
  input  logic hold_sel,
  input  logic hold_val,
  input  logic pol,
  output logic strb,
  output logic pulse_on
);
  import pport_pkg::*;

  localparam int unsigned CNT_W = $clog2(PULSE_CYCLES + 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] run_q;
  logic             act;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)            cnt_q <= '0;
    else if (trig)         cnt_q <= CNT_W'(PULSE_CYCLES);
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;

  assign pulse_on = (cnt_q != '0);
  assign act      = hold_sel ? hold_val : pulse_on;
  assign strb     = drive_level(act, pol);

  // run length of the current pulse, for the width check only
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)        run_q <= '0;
    else if (trig)     run_q <= '0;
    else if (pulse_on) run_q <= run_q + 1'b1;

  assert_pulse_width_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pulse_on) |-> (run_q == CNT_W'(PULSE_CYCLES)));
endmodule

// File: rtl/pport_flag_ctrl.sv
module pport_flag_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic set_evt,
  input  logic rd_status,
  input  logic rd_data,
  input  logic ien,
  output logic flag,
  output logic irq
);
  logic armed_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)         armed_q <= 1'b0;
    else if (rd_status) armed_q <= flag;
    else if (rd_data)   armed_q <= 1'b0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                  flag <= 1'b0;
    else if (set_evt)            flag <= 1'b1;
    else if (rd_data && armed_q) flag <= 1'b0;

  assign irq = flag & ien;

  assert_flag_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> $past(set_evt));
  assert_flag_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag) |-> ($past(rd_data) && !$past(set_evt)));
endmodule

// File: rtl/pport_top.sv
module pport_top #(
  parameter int unsigned DW           = 8,
  parameter int unsigned SYNC_STAGES  = 2,
  parameter int unsigned PULSE_CYCLES = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [pport_pkg::AW-1:0] bus_addr,
  input  logic                   bus_wr,
  input  logic                   bus_rd,
  input  logic [DW-1:0]          bus_wdata,
  output logic [DW-1:0]          bus_rdata,
  input  logic [DW-1:0]          dio_in,
  output logic [DW-1:0]          dio_out,
  output logic [DW-1:0]          dio_oe,
  output logic [DW-1:0]          aux_out,
  input  logic                   stb_in,
  output logic                   stb_out,
  output logic                   irq
);
  import pport_pkg::*;

  localparam int unsigned CW = 7;

  logic [CW-1:0] ctrl_q;
  logic [DW-1:0] latch_q, aux_q, dir_q;
  logic          ready_q, busy_q;
  logic          flag;
  logic          stb_evt;
  logic          pulse_on;
  mode_e         mode;
  logic          pulsed;

  // decoded bus events
  logic rd_ctrl, rd_latch, wr_ctrl, wr_latch, wr_aux, wr_dir;
  assign rd_ctrl  = bus_rd && (bus_addr == A_CTRL);
  assign rd_latch = bus_rd && (bus_addr == A_LATCH);
  assign wr_ctrl  = bus_wr && (bus_addr == A_CTRL);
  assign wr_latch = bus_wr && (bus_addr == A_LATCH);
  assign wr_aux   = bus_wr && (bus_addr == A_AUX);
  assign wr_dir   = bus_wr && (bus_addr == A_DIR);

  assign mode   = mode_of(ctrl_q[C_HS], ctrl_q[C_OUT]);
  assign pulsed = ctrl_q[C_PULSE];

  // internal events, named for the checks
  logic cap_evt, out_load, pulse_trig, hold_sel, hold_val;
  assign cap_evt    = stb_evt && (mode != M_HS_OUT);
  assign out_load   = wr_latch && (mode == M_HS_OUT);
  assign pulse_trig = ((mode == M_SIMPLE) && wr_aux)
                    || ((mode == M_HS_IN)  && pulsed && rd_latch)
                    || ((mode == M_HS_OUT) && pulsed && wr_latch);
  assign hold_sel   = (mode != M_SIMPLE) && !pulsed;
  assign hold_val   = (mode == M_HS_OUT) ? busy_q : ready_q;

  pport_edge_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .pin      (stb_in),
    .rise_sel (ctrl_q[C_RISE]),
    .evt      (stb_evt)
  );

  pport_flag_ctrl i_flag (
    .clk       (clk),
    .rst_n     (rst_n),
    .set_evt   (stb_evt),
    .rd_status (rd_ctrl),
    .rd_data   (rd_latch),
    .ien       (ctrl_q[C_IEN]),
    .flag      (flag),
    .irq       (irq)
  );

  pport_strobe_gen #(.PULSE_CYCLES(PULSE_CYCLES)) i_strobe (
    .clk      (clk),
    .rst_n    (rst_n),
    .trig     (pulse_trig),
    .hold_sel (hold_sel),
    .hold_val (hold_val),
    .pol      (ctrl_q[C_POL]),
    .strb     (stb_out),
    .pulse_on (pulse_on)
  );

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ctrl_q <= '0;
      aux_q  <= '0;
      dir_q  <= '0;
    end else begin
      if (wr_ctrl) ctrl_q <= bus_wdata[CW-1:0];
      if (wr_aux)  aux_q  <= bus_wdata;
      if (wr_dir)  dir_q  <= bus_wdata;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)        latch_q <= '0;
    else if (cap_evt)  latch_q <= dio_in;
    else if (out_load) latch_q <= bus_wdata;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                                        ready_q <= 1'b1;
    else if (stb_evt && (mode == M_HS_IN) && !pulsed)  ready_q <= 1'b0;
    else if (rd_latch)                                 ready_q <= 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                   busy_q <= 1'b0;
    else if (out_load && !pulsed) busy_q <= 1'b1;
    else if (stb_evt)             busy_q <= 1'b0;

  always_comb begin
    bus_rdata = '0;
    unique case (bus_addr)
      A_CTRL:  begin
        bus_rdata[CW-1:0] = ctrl_q;
        bus_rdata[C_FLAG] = flag;
      end
      A_LATCH: bus_rdata = latch_q;
      A_AUX:   bus_rdata = aux_q;
      default: bus_rdata = dir_q;
    endcase
  end

  assign dio_out = latch_q;
  assign dio_oe  = dir_q;
  assign aux_out = aux_q;

  // R9: ready returns only through a capture-register read
  assert_ready_return_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready_q) |-> $past(rd_latch));
  // R11: output strobe level released only by an accepted edge
  assert_busy_release_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> $past(stb_evt));
  // R12: pins driven only from written data or captured input
  assert_latch_source_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(latch_q) |-> ($past(cap_evt) || $past(out_load)));
endmodule

// File: tb/test_pport_top.sv
module test_pport_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] bus_addr = '0;
  logic       bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic [7:0] dio_in = '0;
  logic [7:0] dio_out, dio_oe, aux_out;
  logic       stb_in = 1'b1;
  logic       stb_out, irq;

  int vectors = 0;
  int miscompares = 0;
  string cur_req = "R1";
  logic [7:0] rv;

  always #4 clk = ~clk;

  pport_top i_pport_top (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .dio_in(dio_in), .dio_out(dio_out), .dio_oe(dio_oe), .aux_out(aux_out),
    .stb_in(stb_in), .stb_out(stb_out), .irq(irq)
  );

  // ---------------- behavioural reference ----------------
  logic [6:0] m_ctrl = '0;
  logic [7:0] m_latch = '0, m_aux = '0, m_dir = '0;
  bit         m_flag = 0, m_arm = 0, m_ready = 1, m_busy = 0;
  int         m_pulse = 0;
  bit         pin_hist[$] = '{0, 0, 0};

  always @(posedge clk) begin
    bit hs, od, pl, rise, ev, rdc, rdl, wrl;
    if (!rst_n) begin
      m_ctrl = '0; m_latch = '0; m_aux = '0; m_dir = '0;
      m_flag = 0; m_arm = 0; m_ready = 1; m_busy = 0; m_pulse = 0;
      pin_hist = '{0, 0, 0};
    end else begin
      hs = m_ctrl[4]; od = m_ctrl[3]; pl = m_ctrl[2]; rise = m_ctrl[1];
      ev = rise ? (pin_hist[1] && !pin_hist[0]) : (!pin_hist[1] && pin_hist[0]);
      rdc = bus_rd && bus_addr == 0;
      rdl = bus_rd && bus_addr == 1;
      wrl = bus_wr && bus_addr == 1;
      if (ev && !(hs && od)) m_latch = dio_in;
      else if (wrl && hs && od) m_latch = bus_wdata;
      if (ev) m_flag = 1;
      else if (rdl && m_arm) m_flag = 0;
      if (rdc) m_arm = m_flag || ev ? (m_flag && !ev ? 1 : m_arm_prev(rdc)) : 0;
      if ((!hs && bus_wr && bus_addr == 2) || (hs && pl && !od && rdl) ||
          (hs && pl && od && wrl)) m_pulse = 2;
      else if (m_pulse > 0) m_pulse--;
      if (ev && hs && !od && !pl) m_ready = 0;
      else if (rdl) m_ready = 1;
      if (wrl && hs && od && !pl) m_busy = 1;
      else if (ev) m_busy = 0;
      if (bus_wr && bus_addr == 0) m_ctrl = bus_wdata[6:0];
      if (bus_wr && bus_addr == 2) m_aux = bus_wdata;
      if (bus_wr && bus_addr == 3) m_dir = bus_wdata;
      pin_hist.push_back(stb_in);
      void'(pin_hist.pop_front());
    end
  end

  // arm tracks the flag as it stood before this edge; recorded separately
  bit flag_before = 0;
  always @(negedge clk) flag_before = m_flag;
  function automatic bit m_arm_prev(bit rdc);
    return rdc && flag_before;
  endfunction

  function automatic logic [7:0] m_rdata(logic [1:0] a);
    case (a)
      2'd0: return {m_flag, m_ctrl};
      2'd1: return m_latch;
      2'd2: return m_aux;
      default: return m_dir;
    endcase
  endfunction

  function automatic logic m_stb();
    bit act;
    if (m_ctrl[4] && !m_ctrl[2]) act = m_ctrl[3] ? m_busy : m_ready;
    else act = (m_pulse > 0);
    return m_ctrl[0] ? act : !act;
  endfunction

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      chk(cur_req, "dio_out", dio_out, m_latch);
      chk(cur_req, "dio_oe", dio_oe, m_dir);
      chk(cur_req, "aux_out", aux_out, m_aux);
      chk(cur_req, "stb_out", stb_out, m_stb());
      chk(cur_req, "irq", irq, m_flag && m_ctrl[6]);
      if (bus_rd) chk(cur_req, "rdata", bus_rdata, m_rdata(bus_addr));
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic step(int n = 1);
    repeat (n) begin @(posedge clk); #2; end
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    step();
    bus_wr = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, output logic [7:0] d);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    step();
    bus_rd = 1'b0;
  endtask

  task automatic strobe(logic v);
    stb_in = v;
    step(4);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog expired in %s", cur_req);
    finish_run();
  end

  initial begin
    int cnt;
    step(4);
    #1;
    cur_req = "R1";
    chk("R1", "stb_out reset", stb_out, 1);
    chk("R1", "dio_oe reset", dio_oe, 0);
    chk("R1", "aux_out reset", aux_out, 0);
    chk("R1", "irq reset", irq, 0);
    rst_n = 1'b1;
    step(2);
    rd(0, rv); chk("R1", "ctrl reset", rv, 8'h00);

    cur_req = "R2";
    dio_in = 8'hA5;
    strobe(1'b0);
    rd(0, rv); chk("R2", "flag after falling edge", rv[7], 1);
    rd(1, rv); chk("R2", "captured data", rv, 8'hA5);

    cur_req = "R3";
    dio_in = 8'h3C;
    strobe(1'b1);
    rd(0, rv); chk("R3", "flag after inactive edge", rv[7], 0);
    rd(1, rv); chk("R3", "data after inactive edge", rv, 8'hA5);

    cur_req = "R5";
    strobe(1'b0);
    rd(1, rv); chk("R5", "captured 3C", rv, 8'h3C);
    rd(0, rv); chk("R5", "flag kept without status read", rv[7], 1);
    rd(1, rv);
    rd(0, rv); chk("R5", "flag cleared by sequence", rv[7], 0);

    cur_req = "R4";
    wr(0, 8'h40);
    strobe(1'b1);
    dio_in = 8'h81;
    strobe(1'b0);
    #1 chk("R4", "irq on flag", irq, 1);
    rd(0, rv); rd(1, rv);
    #1 chk("R4", "irq after clear", irq, 0);

    cur_req = "R7";
    wr(0, 8'h43);
    dio_in = 8'h5E;
    strobe(1'b1);
    rd(0, rv); chk("R2", "flag after rising edge", rv[7], 1);
    rd(1, rv); chk("R2", "rising capture", rv, 8'h5E);
    #1 chk("R7", "idle active-high strobe", stb_out, 0);

    cur_req = "R6";
    wr(2, 8'h5A);
    cnt = 0;
    for (int i = 0; i < 4; i++) begin #1 if (stb_out) cnt++; step(); end
    chk("R6", "pulse width", cnt, 2);
    chk("R6", "aux_out", aux_out, 8'h5A);
    wr(0, 8'h00);
    wr(2, 8'hC3);
    cnt = 0;
    for (int i = 0; i < 4; i++) begin #1 if (!stb_out) cnt++; step(); end
    chk("R7", "active-low pulse width", cnt, 2);

    cur_req = "R8";
    wr(0, 8'h14);
    dio_in = 8'h27;
    strobe(1'b1); strobe(1'b0);
    rd(1, rv); chk("R8", "pulsed capture", rv, 8'h27);
    cnt = 0;
    #1 if (!stb_out) cnt++;
    step(); #1 if (!stb_out) cnt++;
    step(); #1 if (!stb_out) cnt++;
    chk("R8", "ack pulse width", cnt, 2);

    cur_req = "R9";
    wr(0, 8'h10);
    rd(1, rv);
    #1 chk("R9", "ready asserted", stb_out, 0);
    strobe(1'b1);
    dio_in = 8'h64;
    strobe(1'b0);
    #1 chk("R9", "ready negated after capture", stb_out, 1);
    rd(1, rv); chk("R9", "interlocked data", rv, 8'h64);
    #1 chk("R9", "ready back after read", stb_out, 0);

    cur_req = "R10";
    wr(0, 8'h1C);
    wr(1, 8'h77);
    #1 chk("R10", "dio_out written", dio_out, 8'h77);
    step(3);
    dio_in = 8'h00;
    strobe(1'b1);
    strobe(1'b0);
    rd(0, rv); chk("R10", "ack sets flag", rv[7], 1);
    rd(1, rv); chk("R10", "latch unchanged", rv, 8'h77);

    cur_req = "R11";
    wr(0, 8'h19);
    wr(1, 8'h99);
    step(5);
    #1 chk("R11", "strobe held", stb_out, 1);
    strobe(1'b1);
    #1 chk("R11", "held through inactive edge", stb_out, 1);
    strobe(1'b0);
    #1 chk("R11", "released by ack", stb_out, 0);

    cur_req = "R12";
    wr(3, 8'hF0);
    #1 chk("R12", "dio_oe", dio_oe, 8'hF0);
    wr(0, 8'h10);
    wr(1, 8'h11);
    rd(1, rv); chk("R12", "input-mode write ignored", rv, 8'h99);

    step(4);
    finish_run();
  end
endmodule